// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a memory-mapped 16-bit timer/counter with a clock prescaler. Software programs a reload value and a control word over a simple synchronous register bus, and the counter then steps once per prescaled tick. It can step up or down. In free-running mode it wraps around between zero and full scale. In periodic mode it reloads from the programmed value each time it reaches its terminal count.

Each terminal count raises a level interrupt. The interrupt stays set until software writes any value to the acknowledge slot. In the cycle the interrupt is raised, the block also drives a single-cycle strobe that can start an analog-to-digital conversion. Reads return data combinationally in the same cycle. The live count can be read at any time.

Top module: `pscl_timer`

## Requirements
- R1: After reset the reload register reads 0x0000, the count reads 0xFFFF, the control word reads 0, and `irq` and `conv_start` are low. The count does not move until a control write sets the enable bit.
- R2: The register slot is chosen by address bits [3:2]: 0 is the reload value (read/write, low 16 bits), 1 is the live count (read-only), 2 is the control word, and 3 is the acknowledge slot, which reads 0. An access hits only if address bits [1:0] and every address bit above bit 3 are zero. A miss writes nothing and reads 0. The control word layout is: bits [1:0] prescale code, bit [2] count up, bit [3] periodic, bit [4] enable.
- R3: Prescale code 00 gives one step per cycle, 01 one step per 16 cycles, 10 one step per 256 cycles, and 11 one step per cycle. The prescaler restarts on every control write and is held at its start while the timer is disabled. The first step therefore lands N clock edges after the edge of the enabling write.
- R4: Counting down in free-running mode, each step subtracts one, and a step from 0x0000 goes to 0xFFFF.
- R5: Counting up in free-running mode, each step adds one, and a step from 0xFFFF goes to 0x0000.
- R6: A control write that enables a disabled timer in periodic mode copies the reload register into the count on that edge. In periodic mode, a step taken at the terminal value (0x0000 down, 0xFFFF up) loads the reload value. A reload write during a run leaves the live count alone and is used at the next reload.
- R7: `irq` goes high on the edge where a step leaves the terminal value. It stays high until a write of any data to the acknowledge slot. If a terminal step and an acknowledge write fall on the same edge, the interrupt stays set.
- R8: `conv_start` is high for exactly the one cycle after each terminal step, together with the rising or renewed `irq`.
- R9: A control write with the enable bit clear freezes the count. Enabling again in free-running mode resumes from the frozen value.
- R10: Writes to the count slot are ignored. A reload write in free-running mode does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, set on terminal count |
| conv_start | output | 1 | One-cycle conversion-start strobe |

## Verification
A write takes effect on the rising edge that samples it. The count first changes N edges after an enabling write, where N is the prescale divisor. `irq` and `conv_start` become visible in the cycle that follows the edge of the terminal step. Read data is valid in the same cycle the address is applied.

The bench drives inputs on falling edges and advances a behavioural reference model on every rising edge. On every falling edge it compares `irq` and `conv_start` with the model. For count and register reads, it sets the address on a falling edge and samples one time unit later, so every comparison is made on settled values away from the active edge.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;

   localparam int CTRL_W = 5;

   typedef enum logic [1:0] {
      SLOT_RELOAD = 2'd0,
      SLOT_COUNT  = 2'd1,
      SLOT_CTRL   = 2'd2,
      SLOT_ACK    = 2'd3
   } slot_e;

   typedef enum logic [1:0] {
      PS_DIV1   = 2'b00,
      PS_DIVLO  = 2'b01,
      PS_DIVHI  = 2'b10,
      PS_DIV1B  = 2'b11
   } psel_e;

   typedef struct packed {
      logic  en;
      logic  periodic;
      logic  up;
      psel_e psel;
   } ctrl_t;

endpackage

// File: rtl/pscl_timer_regs.sv
module pscl_timer_regs
   import pscl_timer_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic [DATA_W-1:0] bus_rdata,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  reload_val,
   output logic              ctrl_wr,
   output logic              ack_wr,
   output logic              start_load
);

   logic        hi_zero;
   logic        hit;
   slot_e       slot;
   ctrl_t       ctrl_q;
   ctrl_t       ctrl_new;
   logic [CNT_W-1:0] reload_q;
   logic        reload_wr;
   logic        unused_wdata_hi;

   generate
      if (ADDR_W > 4) begin : g_hi_addr
         assign hi_zero = ~|bus_addr[ADDR_W-1:4];
      end else begin : g_no_hi_addr
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign hit       = hi_zero && (bus_addr[1:0] == 2'b00);
   assign slot      = slot_e'(bus_addr[3:2]);
   assign ctrl_new  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
   assign reload_wr = bus_wr && hit && (slot == SLOT_RELOAD);
   assign ctrl_wr   = bus_wr && hit && (slot == SLOT_CTRL);
   assign ack_wr    = bus_wr && hit && (slot == SLOT_ACK);
   assign start_load = ctrl_wr && ctrl_new.en && ctrl_new.periodic && !ctrl_q.en;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctrl_q   <= '0;
      end else begin
         if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
         if (ctrl_wr)   ctrl_q   <= ctrl_new;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (slot)
            SLOT_RELOAD: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
            SLOT_COUNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
            SLOT_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            SLOT_ACK:    bus_rdata = '0;
            default:     bus_rdata = '0;
         endcase
      end
   end

   assign ctrl       = ctrl_q;
   assign reload_val = reload_q;

   // R2: a missed access leaves both writable registers untouched
   a_r2_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> ($stable(reload_q) && $stable(ctrl_q)));

   // R2: a reload write lands in the reload register on the next cycle
   a_r2_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
      reload_wr |=> (reload_q == $past(bus_wdata[CNT_W-1:0])));

   // R6: a start load happens only when a disabled timer is enabled
   a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_load |=> (ctrl_q.en && ctrl_q.periodic && !$past(ctrl_q.en)));

endmodule

// File: rtl/pscl_timer_prescale.sv
module pscl_timer_prescale
   import pscl_timer_pkg::*;
#(
   parameter int LO_LOG2 = 4,
   parameter int HI_LOG2 = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  logic  restart,
   input  psel_e psel,
   output logic  tick
);

   localparam int PW = HI_LOG2;
   localparam logic [PW-1:0] P_ONE = {{(PW-1){1'b0}}, 1'b1};

   logic [PW-1:0] pcnt_q;
   logic [3:0]    hit;

   generate
      for (genvar i = 0; i < 4; i++) begin : g_code
         localparam int L = (i == 1) ? LO_LOG2 : ((i == 2) ? HI_LOG2 : 0);
         if (L == 0) begin : g_every
            assign hit[i] = 1'b1;
         end else begin : g_mask
            assign hit[i] = &pcnt_q[L-1:0];
         end
      end
   endgenerate

   assign tick = run && hit[psel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (restart || !run) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + P_ONE;
      end
   end

   // R3: a divided setting never ticks in the cycle right after a restart
   a_r3_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!tick || psel == PS_DIV1 || psel == PS_DIV1B));

   // R3: a stopped prescaler produces no ticks
   a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

endmodule

// File: rtl/pscl_timer_counter.sv
module pscl_timer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             up,
   input  logic             periodic,
   input  logic             start_load,
   input  logic             ack,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             irq,
   output logic             conv_start
);

   localparam logic [CNT_W-1:0] FULL = '1;
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_val;
   logic             at_term;
   logic             term;
   logic             irq_q;
   logic             conv_q;

   assign at_term  = up ? (cnt_q == FULL) : (cnt_q == ZERO);
   assign term     = tick && at_term;
   assign wrap_val = periodic ? reload_val : (up ? ZERO : FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= FULL;
         irq_q  <= 1'b0;
         conv_q <= 1'b0;
      end else begin
         conv_q <= term;
         if (start_load) begin
            cnt_q <= reload_val;
         end else if (tick) begin
            if (at_term)  cnt_q <= wrap_val;
            else if (up)  cnt_q <= cnt_q + ONE;
            else          cnt_q <= cnt_q - ONE;
         end
         if (term)      irq_q <= 1'b1;
         else if (ack)  irq_q <= 1'b0;
      end
   end

   assign cnt        = cnt_q;
   assign irq        = irq_q;
   assign conv_start = conv_q;

   // R4: a non-terminal down step subtracts one
   a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !up && !at_term) |=> (cnt_q == $past(cnt_q) - ONE));

   // R5: a non-terminal up step adds one
   a_r5_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && up && !at_term) |=> (cnt_q == $past(cnt_q) + ONE));

   // R6: a periodic terminal step reloads
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && periodic && at_term) |=> (cnt_q == $past(reload_val)));

   // R7: the interrupt holds until acknowledged
   a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack) |=> irq_q);

   // R7: an acknowledge with no new event clears the interrupt
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !term) |=> !irq_q);

   // R8: the strobe only appears together with the interrupt
   a_r8_strobe_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      conv_q |-> irq_q);

   // R9: without a tick or start load the count is frozen
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !start_load) |=> $stable(cnt_q));

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
   import pscl_timer_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int PS_LO_LOG2 = 4,
   parameter int PS_HI_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              conv_start
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pscl_timer: ADDR_W must be at least 4");
      end
      if (CNT_W < CTRL_W) begin : g_bad_cnt
         $error("pscl_timer: CNT_W must be at least CTRL_W");
      end
      if (DATA_W <= CNT_W) begin : g_bad_data
         $error("pscl_timer: DATA_W must exceed CNT_W");
      end
      if (PS_LO_LOG2 < 1 || PS_HI_LOG2 <= PS_LO_LOG2 || PS_HI_LOG2 > 16) begin : g_bad_ps
         $error("pscl_timer: prescale exponents out of range");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] cnt_val;
   logic             ctrl_wr;
   logic             ack_wr;
   logic             start_load;
   logic             tick;

   pscl_timer_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .cnt_val    (cnt_val),
      .bus_rdata  (bus_rdata),
      .ctrl       (ctrl),
      .reload_val (reload_val),
      .ctrl_wr    (ctrl_wr),
      .ack_wr     (ack_wr),
      .start_load (start_load)
   );

   pscl_timer_prescale #(
      .LO_LOG2 (PS_LO_LOG2),
      .HI_LOG2 (PS_HI_LOG2)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.en),
      .restart (ctrl_wr),
      .psel    (ctrl.psel),
      .tick    (tick)
   );

   pscl_timer_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .up         (ctrl.up),
      .periodic   (ctrl.periodic),
      .start_load (start_load),
      .ack        (ack_wr),
      .reload_val (reload_val),
      .cnt        (cnt_val),
      .irq        (irq),
      .conv_start (conv_start)
   );

   // R1: nothing is signalled while the timer has never been enabled
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en && !$past(ctrl.en)) |-> !conv_start);

endmodule

// File: tb/pscl_timer_test.sv
module pscl_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int MAXV       = 65535;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        conv_start;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   // reference model state
   int m_load, m_val, m_phase, m_sel, m_div, m_old_load;
   bit m_en, m_per, m_up, m_irq, m_trig, m_tick, m_term, m_hit;

   always #(CLK_PERIOD/2) clk = ~clk;

   pscl_timer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq        (irq),
      .conv_start (conv_start)
   );

   function automatic int div_of(input int sel);
      if (sel == 1) return 16;
      if (sel == 2) return 256;
      return 1;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_load = 0; m_val = MAXV; m_phase = 0; m_sel = 0;
         m_en = 0; m_per = 0; m_up = 0; m_irq = 0; m_trig = 0;
      end else begin
         m_old_load = m_load;
         m_div  = div_of(m_sel);
         m_tick = m_en && ((m_phase % m_div) == m_div - 1);
         m_term = m_tick && (m_up ? (m_val == MAXV) : (m_val == 0));
         m_hit  = (bus_addr[1:0] == 2'b00) && (bus_addr[5:4] == 2'b00);
         m_trig = m_term;
         if (m_tick) begin
            if (m_term)    m_val = m_per ? m_old_load : (m_up ? 0 : MAXV);
            else if (m_up) m_val = m_val + 1;
            else           m_val = m_val - 1;
         end
         if (m_term) m_irq = 1;
         else if (bus_wr && m_hit && bus_addr[3:2] == 2'd3) m_irq = 0;
         m_phase = m_en ? m_phase + 1 : 0;
         if (bus_wr && m_hit) begin
            if (bus_addr[3:2] == 2'd0) m_load = int'(bus_wdata[15:0]);
            if (bus_addr[3:2] == 2'd2) begin
               if (bus_wdata[4] && bus_wdata[3] && !m_en) m_val = m_old_load;
               m_en  = bus_wdata[4];
               m_per = bus_wdata[3];
               m_up  = bus_wdata[2];
               m_sel = int'(bus_wdata[1:0]);
               m_phase = 0;
            end
         end
      end
   end

   // every-cycle comparison of the registered outputs
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 irq level", longint'(irq), longint'(m_irq));
         chk("R8 conv_start strobe", longint'(conv_start), longint'(m_trig));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input string req);
      longint exp;
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      exp = 0;
      if (a[1:0] == 2'b00 && a[5:4] == 2'b00) begin
         case (a[3:2])
            2'd0: exp = m_load;
            2'd1: exp = m_val;
            2'd2: exp = {m_en, m_per, m_up, m_sel[1:0]};
            default: exp = 0;
         endcase
      end
      chk(req, longint'(bus_rdata), exp);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      // reset state
      rd(6'h00, "R1 reload after reset");
      rd(6'h04, "R1 count after reset");
      rd(6'h08, "R1 control after reset");
      chk("R1 irq after reset", longint'(irq), 0);
      idle(5);
      rd(6'h04, "R1 count idle before enable");
      // map decode and ignored writes
      wr(6'h04, 32'h1234);
      rd(6'h04, "R10 count slot write ignored");
      wr(6'h14, 32'h7);
      rd(6'h00, "R2 miss on high address bit");
      wr(6'h01, 32'h9);
      rd(6'h00, "R2 miss on low address bits");
      rd(6'h01, "R2 unaligned read returns zero");
      wr(6'h00, 32'hABCD0005);
      rd(6'h00, "R2 reload readback");
      // periodic down at divide by 1
      wr(6'h08, 32'h18);
      rd(6'h04, "R6 start load on enable");
      rd(6'h08, "R2 control readback");
      idle(9);
      rd(6'h04, "R6 periodic down running");
      wr(6'h0C, 32'hDEAD);
      rd(6'h0C, "R7 ack slot reads zero");
      wr(6'h00, 32'h9);
      rd(6'h04, "R6 reload write keeps live count");
      idle(25);
      rd(6'h04, "R6 new reload used");
      // free-running down through zero
      wr(6'h08, 32'h10);
      idle(15);
      rd(6'h04, "R4 free down wrap");
      wr(6'h00, 32'h3);
      rd(6'h04, "R10 reload write in free mode");
      // free-running up through full scale
      wr(6'h08, 32'h14);
      rd(6'h04, "R5 free up start");
      idle(20);
      rd(6'h04, "R5 free up wrap");
      // disable and resume
      wr(6'h08, 32'h04);
      rd(6'h04, "R9 frozen value");
      idle(10);
      rd(6'h04, "R9 still frozen");
      wr(6'h08, 32'h14);
      idle(3);
      rd(6'h04, "R9 resumes from frozen value");
      // divide by 16 periodic
      wr(6'h08, 32'h0);
      wr(6'h00, 32'h2);
      wr(6'h08, 32'h19);
      for (int i = 0; i < 10; i++) begin
         idle(7);
         rd(6'h04, "R3 divide by 16");
      end
      // divide by 256 periodic
      wr(6'h08, 32'h0);
      wr(6'h08, 32'h1A);
      idle(250);
      rd(6'h04, "R3 divide by 256 before step");
      idle(10);
      rd(6'h04, "R3 divide by 256 after step");
      idle(520);
      rd(6'h04, "R3 divide by 256 terminal");
      // code 11 behaves as divide by 1
      wr(6'h08, 32'h0);
      wr(6'h08, 32'h1B);
      idle(2);
      rd(6'h04, "R3 code 11 steps every cycle");
      // periodic up through full scale, with acknowledges near events
      wr(6'h08, 32'h0);
      wr(6'h00, 32'hFFFC);
      wr(6'h08, 32'h1C);
      idle(6);
      rd(6'h04, "R6 periodic up reload");
      for (int i = 0; i < 8; i++) begin
         wr(6'h0C, i);
         rd(6'h04, "R7 acknowledge during run");
      end
      wr(6'h08, 32'h0);
      idle(4);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule